// File: doc/BRIEF.md
# I2C 12-bit Sample Responder

This block is the device side of an I2C read-only data source. It watches the bus clock and data lines, which it synchronises into its own system clock. It recognises START and STOP conditions and compares each address byte with a 7-bit address. The address is a fixed 4-bit device code followed by three bits taken from strap inputs. When a matching read request arrives, the block acknowledges it. It then streams 12-bit sample values taken from a parallel input port, sending each value as two bytes.

The block pulses a one-cycle sample strobe at the bus-clock falling edges where a new acquisition should begin, so that an external converter can start sampling there. The bus master controls the stream. An acknowledge after the low byte requests another sample. A not-acknowledge ends the transfer, and the block stays silent until the next START or STOP. The block only ever pulls the data line low, using an active-low output enable.

Top module: `sampleResponder`

## Requirements
- R1: After reset the data output enable `sdaOeN` is high (line released) and `sampleStrobe` is low.
- R2: Only the address byte {1001, addrPins[2], addrPins[1], addrPins[0], 1} (sent MSB first, R/W last and 1 = read) is acknowledged. Any other address, or a matching address with R/W = 0, leaves SDA released for the rest of the transfer, and no strobe is produced.
- R3: For a matching read, SDA is held low for the whole 9th SCL pulse after START.
- R4: `sampleStrobe` is a single system-clock pulse following the SCL falling edge that ends the R/W bit (the 8th SCL pulse after START).
- R5: The first data byte is four 0 bits followed by sample bits 11 down to 8, sent MSB first.
- R6: After the master acknowledges the first byte, the next 8 SCL pulses carry sample bits 7 down to 0.
- R7: A master NAK (SDA high) after the low byte ends transmission: SDA stays released and no further strobe appears until START or STOP.
- R8: A master ACK after the low byte starts a new upper/lower pair. A strobe follows the SCL falling edge of each D0 bit, so acquisitions are 18 SCL pulses apart.
- R9: The sample value is captured when the upper byte begins. A change on `sampleValue` during a pair does not alter that pair's low byte.
- R10: A START or STOP at any point releases SDA on the next cycle and aborts the transfer. A START returns the block to address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| addrPins | input | 3 | Low three address bits |
| sampleValue | input | 12 | Parallel sample value to serve |
| sdaOeN | output | 1 | Active-low enable of the open-drain data pull-down |
| sampleStrobe | output | 1 | One-cycle pulse marking the start of an acquisition |

## Verification
The bound checker watches timing rules on every cycle. The strobe is always one cycle wide and always follows a detected SCL fall. The data enable changes only after an SCL fall or a START/STOP. Any START or STOP releases the line. The directed scenarios show what those rules cannot: address filtering, the byte contents, the padding, and capture of the value at the start of the upper byte. They also show the exact SCL pulse numbers of the strobes and the silence that follows a NAK or an abort.

// File: rtl/smpResp_pkg.sv
package smpResp_pkg;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
    logic addrHit;
  } busEvt_t;

  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic shiftTx;
    logic ackDrive;
    logic dataDrive;
  } ctlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } respState_t;

endpackage

// File: rtl/smpRespData.sv
module smpRespData
  import smpResp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 3,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1001,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] addrPins,
  input  logic [DATA_W-1:0] sampleValue,
  input  ctlStrb_t          ctl,
  output busEvt_t           evt,
  output logic              sdaOeN
);
  localparam int BYTE_W = 8;
  localparam int HI_BITS = DATA_W - BYTE_W;
  localparam int PAD_BITS = BYTE_W - HI_BITS;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] addrShift, txShift, lowHold;
  logic [BYTE_W-1:0] addrByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  assign addrByte = {addrShift[BYTE_W-2:0], sdaS};

  always_comb begin
    evt.sclRise  = sclS && !sclPrev;
    evt.sclFall  = !sclS && sclPrev;
    evt.startDet = sclS && sclPrev && sdaPrev && !sdaS;
    evt.stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
    evt.sdaBit   = sdaS;
    evt.addrHit  = (addrByte[BYTE_W-1:1] == {DEV_CODE, addrPins});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShift <= '0;
      txShift   <= '1;
      lowHold   <= '0;
    end else begin
      if (ctl.shiftIn) addrShift <= addrByte;
      if (ctl.loadHi) begin
        txShift <= {{PAD_BITS{1'b0}}, sampleValue[DATA_W-1:BYTE_W]};
        lowHold <= sampleValue[BYTE_W-1:0];
      end else if (ctl.loadLo) begin
        txShift <= lowHold;
      end else if (ctl.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b1};
      end
    end
  end

  assign sdaOeN = !(ctl.ackDrive || (ctl.dataDrive && !txShift[BYTE_W-1]));

endmodule

// File: rtl/smpRespCtrl.sv
module smpRespCtrl
  import smpResp_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  busEvt_t  evt,
  output ctlStrb_t ctl,
  output logic     sampleStrobe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  respState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, cntNxt;
  logic ackDrive, ackNxt, dataDrive, dataNxt;
  logic lowerByte, lowNxt, mAck, mAckNxt, strobeNxt;
  logic shiftIn, loadHi, loadLo, shiftTx;

  always_comb begin
    stateNxt  = state;
    cntNxt    = bitCnt;
    ackNxt    = ackDrive;
    dataNxt   = dataDrive;
    lowNxt    = lowerByte;
    mAckNxt   = mAck;
    strobeNxt = 1'b0;
    shiftIn   = 1'b0;
    loadHi    = 1'b0;
    loadLo    = 1'b0;
    shiftTx   = 1'b0;
    if (evt.stopDet) begin
      stateNxt = ST_IDLE;
      ackNxt   = 1'b0;
      dataNxt  = 1'b0;
    end else if (evt.startDet) begin
      stateNxt = ST_ADDR;
      cntNxt   = '0;
      ackNxt   = 1'b0;
      dataNxt  = 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (evt.sclRise) begin
          shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            cntNxt   = '0;
            stateNxt = (evt.addrHit && evt.sdaBit) ? ST_ACK_SETUP : ST_WAIT;
          end else begin
            cntNxt = bitCnt + 1'b1;
          end
        end
        ST_ACK_SETUP: if (evt.sclFall) begin
          ackNxt    = 1'b1;
          strobeNxt = 1'b1;
          stateNxt  = ST_ACK_HOLD;
        end
        ST_ACK_HOLD: if (evt.sclFall) begin
          ackNxt   = 1'b0;
          loadHi   = 1'b1;
          dataNxt  = 1'b1;
          lowNxt   = 1'b0;
          cntNxt   = '0;
          stateNxt = ST_TX;
        end
        ST_TX: if (evt.sclFall) begin
          if (bitCnt == LAST_BIT) begin
            dataNxt   = 1'b0;
            strobeNxt = lowerByte;
            stateNxt  = ST_MACK;
          end else begin
            shiftTx = 1'b1;
            cntNxt  = bitCnt + 1'b1;
          end
        end
        ST_MACK: begin
          if (evt.sclRise) mAckNxt = !evt.sdaBit;
          if (evt.sclFall) begin
            if (mAck) begin
              dataNxt  = 1'b1;
              cntNxt   = '0;
              stateNxt = ST_TX;
              if (lowerByte) begin
                loadHi = 1'b1;
                lowNxt = 1'b0;
              end else begin
                loadLo = 1'b1;
                lowNxt = 1'b1;
              end
            end else begin
              stateNxt = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      bitCnt       <= '0;
      ackDrive     <= 1'b0;
      dataDrive    <= 1'b0;
      lowerByte    <= 1'b0;
      mAck         <= 1'b0;
      sampleStrobe <= 1'b0;
    end else begin
      state        <= stateNxt;
      bitCnt       <= cntNxt;
      ackDrive     <= ackNxt;
      dataDrive    <= dataNxt;
      lowerByte    <= lowNxt;
      mAck         <= mAckNxt;
      sampleStrobe <= strobeNxt;
    end
  end

  always_comb begin
    ctl.shiftIn   = shiftIn;
    ctl.loadHi    = loadHi;
    ctl.loadLo    = loadLo;
    ctl.shiftTx   = shiftTx;
    ctl.ackDrive  = ackDrive;
    ctl.dataDrive = dataDrive;
  end

endmodule

// File: rtl/sampleResponder.sv
module sampleResponder
  import smpResp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 3,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1001,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] addrPins,
  input  logic [DATA_W-1:0] sampleValue,
  output logic              sdaOeN,
  output logic              sampleStrobe
);
  busEvt_t  evt;
  ctlStrb_t ctl;

  smpRespData #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
    .DEV_CODE(DEV_CODE), .SYNC_STAGES(SYNC_STAGES)
  ) dataPath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrPins(addrPins), .sampleValue(sampleValue),
    .ctl(ctl), .evt(evt), .sdaOeN(sdaOeN)
  );

  smpRespCtrl #(.BYTE_W(8)) control (
    .clk(clk), .rstN(rstN), .evt(evt), .ctl(ctl),
    .sampleStrobe(sampleStrobe)
  );

endmodule

// File: rtl/smpRespChecker.sv
module smpRespChecker (
  input logic clk,
  input logic rstN,
  input logic sdaOeN,
  input logic sampleStrobe,
  input logic sclFall,
  input logic startDet,
  input logic stopDet
);
  // R4
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |=> !sampleStrobe);

  // R4
  strobe_follows_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(sclFall));

  // R3
  sda_moves_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOeN) |-> $past(sclFall || startDet || stopDet));

  // R10
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> sdaOeN);

  // R10
  start_releases_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> sdaOeN);

endmodule

bind sampleResponder smpRespChecker respChk (
  .clk(clk), .rstN(rstN), .sdaOeN(sdaOeN), .sampleStrobe(sampleStrobe),
  .sclFall(evt.sclFall), .startDet(evt.startDet), .stopDet(evt.stopDet)
);

// File: tb/sampleResponder_test.sv
module sampleResponder_test;
  localparam int H = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] pins = 3'b101;
  logic [11:0] val = 12'h000;
  logic sdaOeN, strobe;
  wire sdaBus = sdaM & sdaOeN;

  sampleResponder uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .addrPins(pins), .sampleValue(val),
    .sdaOeN(sdaOeN), .sampleStrobe(strobe)
  );

  int checks = 0;
  int fails = 0;
  int fallCnt = 0;
  int fallBase = 0;
  int strobeCnt = 0;
  int strobeBase = 0;
  int strobePos [0:15];

  always @(posedge clk) begin
    if (rstN && strobe) begin
      if (strobeCnt < 16) strobePos[strobeCnt] = fallCnt;
      strobeCnt = strobeCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitH();
    sclM = 1'b1; waitH();
    sdaM = 1'b0; waitH();
    sclM = 1'b0; fallCnt++; waitH();
    fallBase = fallCnt;
    strobeBase = strobeCnt;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitH();
    sclM = 1'b1; waitH();
    sdaM = 1'b1; waitH();
  endtask

  task automatic bitX(input logic b, output logic r);
    sdaM = b; waitH();
    sclM = 1'b1; waitH();
    r = sdaBus; waitH();
    sclM = 1'b0; fallCnt++; waitH();
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ackBit);
    logic r;
    for (int i = 7; i >= 0; i--) bitX(d[i], r);
    bitX(1'b1, ackBit);
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bitX(1'b1, r);
      d[i] = r;
    end
    bitX(!masterAck, r);
  endtask

  function automatic int relStrobe(input int k);
    return strobePos[strobeBase + k] - fallBase;
  endfunction

  task automatic tReset();
    chk(sdaOeN === 1'b1, "R1 sda released after reset", int'(sdaOeN), 1);
    chk(strobe === 1'b0, "R1 strobe low after reset", int'(strobe), 0);
  endtask

  task automatic tSingleRead();
    logic a; logic [7:0] d;
    val = 12'hA5C;
    startCond();
    sendByte(8'b1001_101_1, a);
    chk(a == 1'b0, "R2/R3 address acknowledged", int'(a), 0);
    chk(strobeCnt - strobeBase == 1, "R4 one strobe after R/W", strobeCnt - strobeBase, 1);
    chk(relStrobe(0) == 8, "R4 strobe at 8th fall", relStrobe(0), 8);
    recvByte(1'b1, d);
    chk(d == 8'h0A, "R5 upper byte padded", int'(d), 8'h0A);
    recvByte(1'b0, d);
    chk(d == 8'h5C, "R6 lower byte", int'(d), 8'h5C);
    chk(relStrobe(1) == 26, "R8 strobe at D0 fall", relStrobe(1), 26);
    chk(sdaOeN === 1'b1, "R7 released after NAK", int'(sdaOeN), 1);
    recvByte(1'b1, d);
    chk(d == 8'hFF, "R7 silent after NAK", int'(d), 8'hFF);
    chk(strobeCnt - strobeBase == 2, "R7 no strobe after NAK", strobeCnt - strobeBase, 2);
    stopCond();
  endtask

  task automatic tWrongAddr();
    logic a; logic [7:0] d;
    startCond();
    sendByte(8'b1001_011_1, a);
    chk(a == 1'b1, "R2 other address not acked", int'(a), 1);
    recvByte(1'b1, d);
    chk(d == 8'hFF, "R2 other address silent", int'(d), 8'hFF);
    stopCond();
    startCond();
    sendByte(8'b0001_101_1, a);
    chk(a == 1'b1, "R2 wrong device code not acked", int'(a), 1);
    stopCond();
    startCond();
    sendByte(8'b1001_101_0, a);
    chk(a == 1'b1, "R2 write request not acked", int'(a), 1);
    recvByte(1'b1, d);
    chk(d == 8'hFF, "R2 write request silent", int'(d), 8'hFF);
    chk(strobeCnt == strobeBase, "R2 no strobe on mismatch", strobeCnt - strobeBase, 0);
    stopCond();
  endtask

  task automatic tStream();
    logic a; logic [7:0] d;
    val = 12'h123;
    startCond();
    sendByte(8'b1001_101_1, a);
    chk(a == 1'b0, "R2 stream address acked", int'(a), 0);
    recvByte(1'b1, d);
    chk(d == 8'h01, "R5 stream upper 1", int'(d), 8'h01);
    val = 12'hABC;
    recvByte(1'b1, d);
    chk(d == 8'h23, "R9 lower byte kept from capture", int'(d), 8'h23);
    recvByte(1'b1, d);
    chk(d == 8'h0A, "R8 second upper byte", int'(d), 8'h0A);
    val = 12'h456;
    recvByte(1'b0, d);
    chk(d == 8'hBC, "R9 second lower byte", int'(d), 8'hBC);
    chk(strobeCnt - strobeBase == 3, "R8 three strobes", strobeCnt - strobeBase, 3);
    chk(relStrobe(2) == 44, "R8 third strobe position", relStrobe(2), 44);
    chk(relStrobe(2) - relStrobe(1) == 18, "R8 18 pulses per sample",
        relStrobe(2) - relStrobe(1), 18);
    stopCond();
  endtask

  task automatic tAbort();
    logic a, r; logic [7:0] d;
    val = 12'h0FF;
    startCond();
    for (int i = 0; i < 4; i++) bitX((i == 0 || i == 3), r);
    startCond();
    sendByte(8'b1001_101_1, a);
    chk(a == 1'b0, "R10 restart then address acked", int'(a), 0);
    recvByte(1'b1, d);
    chk(d == 8'h00, "R10 upper after restart", int'(d), 8'h00);
    for (int i = 0; i < 3; i++) bitX(1'b1, r);
    stopCond();
    repeat (4) @(negedge clk);
    chk(sdaOeN === 1'b1, "R10 released after STOP", int'(sdaOeN), 1);
    recvByte(1'b1, d);
    chk(d == 8'hFF, "R10 silent after STOP", int'(d), 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", fallCnt, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tSingleRead();
    tWrongAddr();
    tStream();
    tAbort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule